// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps recently used translation words close to the address path so that most 32-bit virtual addresses on 4 KB pages can be turned into physical addresses without walking the page tables in memory. It holds 16 sets of 4 ways. Each way stores a valid bit, a type bit (1 for a directory-level word, 0 for a page-level word), a 16-bit tag and the 32-bit cached translation word.

There are two lookup paths. A page lookup takes a 20-bit virtual page number and a 12-bit page offset. On a hit it returns the physical address and the low flag bits of the cached word. A directory lookup takes a 10-bit directory index and returns the whole cached directory word. On a miss, an external table walker fetches the word from memory and installs it through the fill port.

A flush input stands for a task switch. In one cycle it drops every entry whose global flag is clear. Permission checks and the table walk itself belong to neighbouring blocks.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is invalid. Every page lookup and every directory lookup misses, and `lk_done_o` and `dl_done_o` are low until a request arrives.
- R2: A lookup presented in cycle N has its result valid on the outputs in cycle N+1. The done flag is high for exactly that cycle, and a hit flag is never high without its done flag.
- R3: On a page hit, `lk_paddr_o` equals bits [31:12] of the cached word followed by the 12-bit request offset, and `lk_flags_o` equals bits [11:0] of the cached word. On any miss, both outputs are zero.
- R4: The set index is bits [3:0] of the key and the tag is bits [19:4]. Up to 4 keys with the same set index and different tags are held at the same time.
- R5: Page lookups match only entries of type 0. Directory lookups match only entries of type 1, keyed by {10'b0, dir_idx}. A directory fill uses only `fill_key_i[9:0]`. On a miss, `dl_entry_o` is zero.
- R6: A fill whose key is not present goes to the lowest-numbered invalid way of its set.
- R7: When the set is full and the key is not present, a fill replaces the way named by that set's round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo 4, only on such a replacement.
- R8: A fill whose key and type match a valid entry overwrites that entry in place. No lookup ever matches more than one way.
- R9: A flush clears, in the same clock edge, every valid entry whose cached word has bit 8 equal to 0. Entries with bit 8 equal to 1 stay valid.
- R10: A lookup in the same cycle as a fill or flush sees the contents from before that edge. When a fill and a flush occur together, the filled entry stays valid, with its way chosen from the contents before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Page lookup request |
| lk_vpn_i | input | 20 | Virtual page number to translate |
| lk_off_i | input | 12 | Page offset carried into the physical address |
| lk_done_o | output | 1 | Page lookup result valid |
| lk_hit_o | output | 1 | Page lookup hit |
| lk_paddr_o | output | 32 | Physical address on hit |
| lk_flags_o | output | 12 | Low flag bits of the cached page word |
| dl_req_i | input | 1 | Directory lookup request |
| dl_idx_i | input | 10 | Directory index |
| dl_done_o | output | 1 | Directory lookup result valid |
| dl_hit_o | output | 1 | Directory lookup hit |
| dl_entry_o | output | 32 | Cached directory word on hit |
| fill_i | input | 1 | Install an entry |
| fill_dir_i | input | 1 | Type of installed entry: 1 directory, 0 page |
| fill_key_i | input | 20 | Key of installed entry (page number or index in bits [9:0]) |
| fill_entry_i | input | 32 | Translation word to install |
| flush_i | input | 1 | Task switch: invalidate non-global entries |

## Verification
The stimulus covers several patterns, each aimed at a different failure:
- **Same-set, different-tag fills** separate a correct tag compare from aliasing on the set index alone.
- **Overfilling one set five and six times** exposes the replacement order, so a stuck or shared round-robin pointer shows up as the wrong surviving key.
- **Identical keys installed with both type values** tell the directory path from the page path.
- **Refilling a present key** catches duplicate allocation.
- **Mixed global and non-global entries around a flush**, including a flush coinciding with a fill or a lookup, separate per-entry flush logic from a blanket clear, and show the ordering rule within a single edge.
- **A long pseudo-random run of fills, lookups and flushes** is checked against the behavioural model on every cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_SETS    = 16;
  localparam int unsigned TLB_WAYS    = 4;
  localparam int unsigned TLB_VPN_W   = 20;
  localparam int unsigned TLB_OFF_W   = 12;
  localparam int unsigned TLB_DIR_W   = 10;
  localparam int unsigned TLB_GLB_BIT = 8;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0]            dir_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic                       want_dir_i,
  input  logic [TAG_W-1:0]           key_tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (dir_i[w] == want_dir_i) && (tag_i[w] == key_tag_i);
  end
  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] ptr_i,
  input  logic             match_i,
  input  logic [WAYS-1:0]  match_vec_i,
  output logic [WAY_W-1:0] way_o,
  output logic             advance_o
);
  logic [WAY_W-1:0] first_inv, match_way;
  logic             any_inv;

  always_comb begin
    first_inv = '0;
    match_way = '0;
    any_inv   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        first_inv = WAY_W'(w);
        any_inv   = 1'b1;
      end
      if (match_vec_i[w]) match_way = WAY_W'(w);
    end
  end

  always_comb begin
    if (match_i)      way_o = match_way;
    else if (any_inv) way_o = first_inv;
    else              way_o = ptr_i;
  end
  assign advance_o = use_i && !match_i && !any_inv;

  // an allocation with free space must never land on a live way
  assert_free_way_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && !match_i && !(&valid_i)) |-> !valid_i[way_o]);
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_pkg::*;
#(
  parameter int unsigned SETS    = TLB_SETS,
  parameter int unsigned WAYS    = TLB_WAYS,
  parameter int unsigned VPN_W   = TLB_VPN_W,
  parameter int unsigned OFF_W   = TLB_OFF_W,
  parameter int unsigned DIR_W   = TLB_DIR_W,
  parameter int unsigned GLB_BIT = TLB_GLB_BIT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lk_req_i,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  input  logic [OFF_W-1:0]       lk_off_i,
  output logic                   lk_done_o,
  output logic                   lk_hit_o,
  output logic [VPN_W+OFF_W-1:0] lk_paddr_o,
  output logic [OFF_W-1:0]       lk_flags_o,
  input  logic                   dl_req_i,
  input  logic [DIR_W-1:0]       dl_idx_i,
  output logic                   dl_done_o,
  output logic                   dl_hit_o,
  output logic [VPN_W+OFF_W-1:0] dl_entry_o,
  input  logic                   fill_i,
  input  logic                   fill_dir_i,
  input  logic [VPN_W-1:0]       fill_key_i,
  input  logic [VPN_W+OFF_W-1:0] fill_entry_i,
  input  logic                   flush_i
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - SET_W;
  localparam int unsigned PTE_W = VPN_W + OFF_W;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dir_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0][PTE_W-1:0] data_q  [SETS];
  logic [WAY_W-1:0]           ptr_q   [SETS];

  function automatic logic [PTE_W-1:0] pick(input logic [WAYS-1:0] vec,
                                             input logic [WAYS-1:0][PTE_W-1:0] d);
    logic [PTE_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (vec[w]) r = r | d[w];
    return r;
  endfunction

  // page lookup
  logic [SET_W-1:0] pg_set;
  logic [WAYS-1:0]  pg_vec;
  logic             pg_hit;
  logic [PTE_W-1:0] pg_word;
  assign pg_set = lk_vpn_i[SET_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pg_match (
    .valid_i(valid_q[pg_set]), .dir_i(dir_q[pg_set]), .tag_i(tag_q[pg_set]),
    .want_dir_i(1'b0), .key_tag_i(lk_vpn_i[VPN_W-1:SET_W]),
    .hit_vec_o(pg_vec), .hit_o(pg_hit));
  assign pg_word = pick(pg_vec, data_q[pg_set]);

  // directory lookup, keyed by zero-extended index
  logic [VPN_W-1:0] dl_key;
  logic [SET_W-1:0] dl_set;
  logic [WAYS-1:0]  dl_vec;
  logic             dl_hit;
  assign dl_key = {{(VPN_W-DIR_W){1'b0}}, dl_idx_i};
  assign dl_set = dl_key[SET_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_dl_match (
    .valid_i(valid_q[dl_set]), .dir_i(dir_q[dl_set]), .tag_i(tag_q[dl_set]),
    .want_dir_i(1'b1), .key_tag_i(dl_key[VPN_W-1:SET_W]),
    .hit_vec_o(dl_vec), .hit_o(dl_hit));

  // fill path
  logic [VPN_W-1:0] f_key;
  logic [SET_W-1:0] f_set;
  logic [WAYS-1:0]  f_vec;
  logic             f_match;
  logic [WAY_W-1:0] f_way;
  logic             f_adv;
  assign f_key = fill_dir_i ? {{(VPN_W-DIR_W){1'b0}}, fill_key_i[DIR_W-1:0]} : fill_key_i;
  assign f_set = f_key[SET_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
    .valid_i(valid_q[f_set]), .dir_i(dir_q[f_set]), .tag_i(tag_q[f_set]),
    .want_dir_i(fill_dir_i), .key_tag_i(f_key[VPN_W-1:SET_W]),
    .hit_vec_o(f_vec), .hit_o(f_match));

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .clk_i, .rst_ni, .use_i(fill_i), .valid_i(valid_q[f_set]), .ptr_i(ptr_q[f_set]),
    .match_i(f_match), .match_vec_i(f_vec), .way_o(f_way), .advance_o(f_adv));

  // storage: flush first, fill last so a coincident fill survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (flush_i) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (!data_q[s][w][GLB_BIT]) valid_q[s][w] <= 1'b0;
      end
      if (fill_i) begin
        valid_q[f_set][f_way] <= 1'b1;
        if (f_adv) ptr_q[f_set] <= ptr_q[f_set] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      dir_q[f_set][f_way]  <= fill_dir_i;
      tag_q[f_set][f_way]  <= f_key[VPN_W-1:SET_W];
      data_q[f_set][f_way] <= fill_entry_i;
    end
  end

  // registered results
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o  <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
      lk_flags_o <= '0;
      dl_done_o  <= 1'b0;
      dl_hit_o   <= 1'b0;
      dl_entry_o <= '0;
    end else begin
      lk_done_o  <= lk_req_i;
      lk_hit_o   <= lk_req_i && pg_hit;
      lk_paddr_o <= (lk_req_i && pg_hit) ? {pg_word[PTE_W-1:OFF_W], lk_off_i} : '0;
      lk_flags_o <= (lk_req_i && pg_hit) ? pg_word[OFF_W-1:0] : '0;
      dl_done_o  <= dl_req_i;
      dl_hit_o   <= dl_req_i && dl_hit;
      dl_entry_o <= (dl_req_i && dl_hit) ? pick(dl_vec, data_q[dl_set]) : '0;
    end
  end

  // any surviving non-global entry
  logic ng_live;
  always_comb begin
    ng_live = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (valid_q[s][w] && !data_q[s][w][GLB_BIT]) ng_live = 1'b1;
  end

  assert_single_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pg_vec) && $onehot0(dl_vec) && $onehot0(f_vec));
  assert_hit_has_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_done_o);
  assert_dir_hit_has_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_hit_o |-> dl_done_o);
  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !fill_i) |=> !ng_live);
  assert_miss_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0 && lk_flags_o == '0));
endmodule

// File: tb/tlb_xlat_tb.sv
module tlb_xlat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        lk_req = 0, dl_req = 0, fill = 0, fill_dir = 0, flush = 0;
  logic [19:0] lk_vpn = 0, fill_key = 0;
  logic [11:0] lk_off = 0;
  logic [9:0]  dl_idx = 0;
  logic [31:0] fill_entry = 0;
  logic        lk_done, lk_hit, dl_done, dl_hit;
  logic [31:0] lk_paddr, dl_entry;
  logic [11:0] lk_flags;

  tlb_xlat dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_off_i(lk_off),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr), .lk_flags_o(lk_flags),
    .dl_req_i(dl_req), .dl_idx_i(dl_idx),
    .dl_done_o(dl_done), .dl_hit_o(dl_hit), .dl_entry_o(dl_entry),
    .fill_i(fill), .fill_dir_i(fill_dir), .fill_key_i(fill_key), .fill_entry_i(fill_entry),
    .flush_i(flush));

  int checks = 0, errors = 0;

  // behavioural model: flat list of slots per set plus a pointer per set
  bit          m_v [16][4];
  bit          m_d [16][4];
  int          m_t [16][4];
  logic [31:0] m_w [16][4];
  int          m_p [16];

  function automatic int m_find(bit dir, int key);
    int s = key % 16;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_d[s][w] == dir && m_t[s][w] == key / 16) return w;
    return -1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit lr, int vpn, int off, bit dr, int idx,
                      bit f, bit fd, int fk, logic [31:0] fe, bit fl);
    int pw, dw, s, key, w, fw;
    bit e_lh, e_dh;
    logic [31:0] e_pa, e_fl, e_de;
    @(negedge clk);
    lk_req = lr; lk_vpn = 20'(vpn); lk_off = 12'(off);
    dl_req = dr; dl_idx = 10'(idx);
    fill = f; fill_dir = fd; fill_key = 20'(fk); fill_entry = fe; flush = fl;
    // expected results from contents before the edge
    pw = m_find(1'b0, vpn);
    dw = m_find(1'b1, idx);
    e_lh = lr && pw >= 0;
    e_pa = e_lh ? {m_w[vpn % 16][pw][31:12], 12'(off)} : 32'h0;
    e_fl = e_lh ? {20'h0, m_w[vpn % 16][pw][11:0]} : 32'h0;
    e_dh = dr && dw >= 0;
    e_de = e_dh ? m_w[idx % 16][dw] : 32'h0;
    // model update: victim on old contents, then flush, then install
    key = fd ? (fk % 1024) : fk;
    s = key % 16;
    fw = -1;
    if (f) begin
      fw = m_find(fd, key);
      if (fw < 0) begin
        for (w = 3; w >= 0; w--) if (!m_v[s][w]) fw = w;
        if (fw < 0) begin fw = m_p[s]; m_p[s] = (m_p[s] + 1) % 4; end
      end
    end
    if (fl)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 4; b++)
          if (!m_w[a][b][8]) m_v[a][b] = 0;
    if (f) begin
      m_v[s][fw] = 1; m_d[s][fw] = fd; m_t[s][fw] = key / 16; m_w[s][fw] = fe;
    end
    @(posedge clk);
    #2;
    chk(req, "lk_done R2", 32'(lk_done), 32'(lr));
    chk(req, "lk_hit", 32'(lk_hit), 32'(e_lh));
    chk(req, "lk_paddr R3", lk_paddr, e_pa);
    chk(req, "lk_flags R3", 32'(lk_flags), e_fl);
    chk(req, "dl_done R2", 32'(dl_done), 32'(dr));
    chk(req, "dl_hit R5", 32'(dl_hit), 32'(e_dh));
    chk(req, "dl_entry R5", dl_entry, e_de);
  endtask

  task automatic look(string req, int vpn);
    step(req, 1, vpn, (vpn * 7) % 4096, 0, 0, 0, 0, 0, 32'h0, 0);
  endtask
  task automatic put(string req, int key, logic [31:0] w);
    step(req, 0, 0, 0, 0, 0, 1, 0, key, w, 0);
  endtask

  initial begin
    int seed;
    for (int a = 0; a < 16; a++) begin
      m_p[a] = 0;
      for (int b = 0; b < 4; b++) begin
        m_v[a][b] = 0; m_d[a][b] = 0; m_t[a][b] = 0; m_w[a][b] = 0;
      end
    end
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "lk_done after reset", 32'(lk_done), 32'h0);
    chk("R1", "dl_done after reset", 32'(dl_done), 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look("R1", 20'h12345);
    step("R1", 0, 0, 0, 1, 10'h045, 0, 0, 0, 32'h0, 0);

    // R10: lookup in the fill cycle sees old contents, then R2/R3 hit
    step("R10", 1, 20'h12345, 12'h9ab, 0, 0, 1, 0, 20'h12345, 32'habcde067, 0);
    step("R3", 1, 20'h12345, 12'h9ab, 0, 0, 0, 0, 0, 32'h0, 0);

    // R4: four tags in set 5, plus a different set
    for (int i = 0; i < 4; i++) put("R4", (i + 1) * 16 + 5, 32'h11111000 * (i + 1) + 32'h3);
    for (int i = 0; i < 4; i++) look("R4", (i + 1) * 16 + 5);
    look("R4", 16 + 6);

    // R7: overfill set 5, evictions follow the pointer
    put("R7", 5 * 16 + 5, 32'h55555007);
    look("R7", 16 + 5);
    look("R7", 32 + 5);
    put("R7", 6 * 16 + 5, 32'h66666007);
    look("R7", 32 + 5);
    look("R7", 5 * 16 + 5);

    // R8: refill a present key in place
    put("R8", 3 * 16 + 5, 32'h77777fff);
    look("R8", 3 * 16 + 5);
    look("R8", 4 * 16 + 5);
    look("R8", 6 * 16 + 5);

    // R5: same key under both types
    step("R5", 0, 0, 0, 0, 0, 1, 1, 20'hfc045, 32'hd0d0d127, 0);
    look("R5", 20'h00045);
    step("R5", 0, 0, 0, 1, 10'h045, 0, 0, 0, 32'h0, 0);
    put("R5", 20'h00045, 32'hbeef0005);
    step("R5", 1, 20'h00045, 12'h010, 1, 10'h045, 0, 0, 0, 32'h0, 0);

    // R9: globals survive a flush
    put("R9", 20'h0a0a2, 32'h0a0a2100);
    put("R9", 20'h0b0b2, 32'h0b0b2003);
    step("R9", 1, 20'h0a0a2, 12'h001, 0, 0, 0, 0, 0, 32'h0, 1);
    look("R9", 20'h0a0a2);
    look("R9", 20'h0b0b2);
    look("R9", 20'h12345);

    // R10: fill and flush together; R6: holes refilled lowest first
    step("R10", 0, 0, 0, 0, 0, 1, 0, 20'h0c0c2, 32'h0c0c2001, 1);
    look("R10", 20'h0c0c2);
    look("R10", 20'h0a0a2);
    put("R6", 20'h0d0d2, 32'h0d0d2001);
    put("R6", 20'h0e0e2, 32'h0e0e2001);
    put("R6", 20'h0f0f2, 32'h0f0f2001);
    look("R6", 20'h0a0a2);
    look("R6", 20'h0d0d2);
    look("R6", 20'h0f0f2);

    // mixed random traffic against the model
    seed = 32'h1d2c3b4a;
    for (int i = 0; i < 3000; i++) begin
      int r1, r2, r3;
      seed = seed * 1103515245 + 12345; r1 = (seed >>> 8) & 32'hffffff;
      seed = seed * 1103515245 + 12345; r2 = (seed >>> 8) & 32'hffffff;
      seed = seed * 1103515245 + 12345; r3 = (seed >>> 8) & 32'hffffff;
      step("R7", r1[0], (r1 >> 4) & 32'hff0ff, r2 & 32'hfff, r1[1], (r2 >> 12) & 32'h3f,
           r1[2] | r1[3], r1[28] & r1[29], (r3 >> 2) & 32'hff0ff,
           {r3[23:0], r2[7:0]}, (r1[19:12] == 8'h00));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule